// File: doc/BRIEF.md
# Frame-Synchronous Serial PCM Time-Slot Port

This block serves one channel on a 2.048 MHz serial highway framed by an active-low enable strobe. When the strobe is seen low, the block opens an eight-bit time slot. In that slot it shifts an outgoing PCM byte onto a three-state data line, modelled as a data bit plus an output-enable. It also assembles an incoming PCM byte and an incoming control byte, which arrive side by side on two serial inputs. Outgoing bits change on rising clock edges. Incoming bits are taken on falling edges. Every byte travels most significant bit first.

A three-level address input is read at the start of each slot and chooses where the control byte goes. At the low or middle level the control byte lands in control register A and the PCM byte is exchanged. At the high level the PCM line stays released, no PCM byte is delivered, and the control byte lands in register B. A second strobe later in the same frame, with the address high, is the normal way to load register B.

A digital loopback input makes the port transmit the PCM byte it last received instead of the encoder byte. In loopback the byte handed to the decoder is zero. Completed bytes are handed to other logic with one-cycle valid pulses.

Top module: `pcm_slot_port`

## Requirements
- R1: During and straight after reset, tx_oe, rx_valid, ctl_a_valid and ctl_b_valid are 0, and rx_word, ctl_a and ctl_b are all zero.
- R2: A slot starts at a rising edge where strobe_n is low, the previous rising-edge sample of strobe_n was high, and no slot is in progress. From that edge, with address LOW (2'b00) or MID (2'b01), tx_oe is 1 and tx_bit carries bit 7 of tx_word.
- R3: tx_bit moves to the next lower bit at each of the following seven rising edges. tx_oe returns to 0 at the eighth rising edge after the start edge.
- R4: rx_bit is sampled on the eight falling edges that follow the rising edges of the slot, first sample into bit 7. At the eighth rising edge rx_word takes the byte and rx_valid is 1 for exactly one cycle.
- R5: With address LOW or MID, the byte on ctl_bit, sampled like rx_bit, is written to ctl_a with a one-cycle ctl_a_valid pulse in the same cycle as rx_valid.
- R6: With address HIGH (2'b10 or 2'b11), tx_oe stays 0 and rx_valid stays 0 for the slot. The control byte goes to ctl_b with a one-cycle ctl_b_valid pulse, and ctl_a is left unchanged.
- R7: A slot always runs eight bits. If strobe_n stays low during or past a slot, no new slot begins until strobe_n has been sampled high.
- R8: A second strobe in the same frame, with address HIGH, loads ctl_b and leaves rx_word and ctl_a as they were.
- R9: When dig_loop is 1 at the start edge, the slot transmits the last PCM byte received in a LOW/MID slot (zero after reset) instead of tx_word. When dig_loop is 1 at the end edge, rx_word is written as zero while rx_valid still pulses.
- R10: The address level is taken only at the start edge. A change of addr_lvl during the slot alters neither the output enable nor the control byte's destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 1 | Active-low frame/enable strobe |
| addr_lvl | input | 2 | Address level: 00 LOW, 01 MID, 1x HIGH |
| rx_bit | input | 1 | Serial PCM data in |
| ctl_bit | input | 1 | Serial control data in |
| tx_word | input | 8 | Encoder byte to transmit |
| dig_loop | input | 1 | Digital loopback select |
| tx_bit | output | 1 | Serial PCM data out |
| tx_oe | output | 1 | Output enable of tx_bit |
| rx_word | output | 8 | Received PCM byte toward the decoder |
| rx_valid | output | 1 | One-cycle pulse: rx_word updated |
| ctl_a | output | 8 | Control register A |
| ctl_a_valid | output | 1 | One-cycle pulse: ctl_a written |
| ctl_b | output | 8 | Control register B |
| ctl_b_valid | output | 1 | One-cycle pulse: ctl_b written |

## Verification
The bench sends asymmetric bytes through the port, so a design that swaps bit order or samples on the wrong edge delivers a shifted or mirrored byte. It holds the strobe low across the end of a slot. A design that restarts on a level rather than on a high-to-low sample then produces an extra byte, and the scoreboard reports it as unexpected. It runs a high-address slot after a normal one and flips the address in mid-slot. This exposes designs that drive the line, overwrite register A or rx_word, or re-read the address late. Loopback slots check that the previously received byte goes out and that the decoder sees zero.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [1:0]   addr_lvl,
  input  logic         rx_bit,
  input  logic         ctl_bit,
  input  logic [W-1:0] tx_word,
  input  logic         dig_loop,
  output logic         tx_bit,
  output logic         tx_oe,
  output logic [W-1:0] rx_word,
  output logic         rx_valid,
  output logic [W-1:0] ctl_a,
  output logic         ctl_a_valid,
  output logic [W-1:0] ctl_b,
  output logic         ctl_b_valid
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          stb_hi_seen;
  logic          active;
  logic          mode_hi;
  logic [CW-1:0] cnt;
  logic [W-1:0]  tx_sh, rx_sh, ctl_sh, loop_word;
  logic          start, last;

  assign start  = !strobe_n && stb_hi_seen && !active;
  assign last   = active && (cnt == LAST);
  assign tx_bit = tx_sh[W-1];
  assign tx_oe  = active && !mode_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_hi_seen <= 1'b0;
      active      <= 1'b0;
      mode_hi     <= 1'b0;
      cnt         <= '0;
      tx_sh       <= '0;
    end else begin
      stb_hi_seen <= strobe_n;
      if (start) begin
        active  <= 1'b1;
        cnt     <= '0;
        mode_hi <= addr_lvl[1];
        tx_sh   <= dig_loop ? loop_word : tx_word;
      end else if (active) begin
        tx_sh <= tx_sh << 1;
        cnt   <= cnt + 1'b1;
        if (last) active <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh  <= '0;
      ctl_sh <= '0;
    end else if (active) begin
      rx_sh  <= {rx_sh[W-2:0], rx_bit};
      ctl_sh <= {ctl_sh[W-2:0], ctl_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word     <= '0;
      ctl_a       <= '0;
      ctl_b       <= '0;
      loop_word   <= '0;
      rx_valid    <= 1'b0;
      ctl_a_valid <= 1'b0;
      ctl_b_valid <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      ctl_a_valid <= 1'b0;
      ctl_b_valid <= 1'b0;
      if (last) begin
        if (!mode_hi) begin
          rx_word     <= dig_loop ? '0 : rx_sh;
          loop_word   <= rx_sh;
          ctl_a       <= ctl_sh;
          rx_valid    <= 1'b1;
          ctl_a_valid <= 1'b1;
        end else begin
          ctl_b       <= ctl_sh;
          ctl_b_valid <= 1'b1;
        end
      end
    end
  end

  AST_HI_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start && addr_lvl[1] |=> !tx_oe); // R6
  AST_OE_END_WITH_A: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> ctl_a_valid); // R3
  AST_RX_WITH_A: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ctl_a_valid); // R5
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_a_valid, ctl_b_valid})); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_B_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b_valid |-> $stable(ctl_a)); // R8
endmodule

// File: tb/pcm_slot_port_test.sv
module pcm_slot_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic [1:0] addr_lvl = 2'b00;
  logic       rx_bit = 1'b0, ctl_bit = 1'b0, dig_loop = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       tx_bit, tx_oe, rx_valid, ctl_a_valid, ctl_b_valid;
  logic [7:0] rx_word, ctl_a, ctl_b;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  logic [7:0] last_rx = 8'h00;
  logic [7:0] cur_a = 8'h00;

  always #10 clk = ~clk;

  pcm_slot_port uut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .addr_lvl(addr_lvl),
    .rx_bit(rx_bit), .ctl_bit(ctl_bit), .tx_word(tx_word), .dig_loop(dig_loop),
    .tx_bit(tx_bit), .tx_oe(tx_oe), .rx_word(rx_word), .rx_valid(rx_valid),
    .ctl_a(ctl_a), .ctl_a_valid(ctl_a_valid), .ctl_b(ctl_b), .ctl_b_valid(ctl_b_valid));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pop_cmp(input logic [1:0] kind, input logic [7:0] data, input string req);
    if (exp_q.size() == 0) chk(1'b0, {req, " unexpected byte"}, data, 8'hxx);
    else begin
      logic [9:0] e;
      e = exp_q.pop_front();
      chk(e == {kind, data}, req, data, e[7:0]);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #5;
      if (rst_n) begin
        if (rx_valid) pop_cmp(2'd0, rx_word, "R4 rx_word");
        if (ctl_a_valid) pop_cmp(2'd1, ctl_a, "R5 ctl_a");
        if (ctl_b_valid) pop_cmp(2'd2, ctl_b, "R6 ctl_b");
      end
    end
  end

  task automatic slot(input logic [1:0] a, input logic [1:0] a_late, input logic [7:0] tx,
                      input logic [7:0] rx, input logic [7:0] ctl, input bit lp, input bit hold_low,
                      input string req);
    bit hi;
    logic [7:0] exp_tx;
    hi = a[1];
    exp_tx = lp ? last_rx : tx;
    if (!hi) begin
      exp_q.push_back({2'd0, lp ? 8'h00 : rx});
      exp_q.push_back({2'd1, ctl});
      last_rx = rx;
      cur_a = ctl;
    end else exp_q.push_back({2'd2, ctl});
    @(posedge clk); #2;
    strobe_n = 1'b0; addr_lvl = a; tx_word = tx; dig_loop = lp;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2;
      if (!hold_low) strobe_n = 1'b1;
      tx_word = ~tx;
      rx_bit = rx[7-k]; ctl_bit = ctl[7-k];
      if (k == 3) addr_lvl = a_late;
      #3;
      chk(tx_oe == !hi, {req, " oe in slot"}, {7'd0, tx_oe}, {7'd0, !hi});
      if (!hi) chk(tx_bit == exp_tx[7-k], {req, " tx bit"}, {7'd0, tx_bit}, {7'd0, exp_tx[7-k]});
    end
    @(posedge clk); #5;
    chk(tx_oe == 1'b0, "R3 oe released after eighth edge", {7'd0, tx_oe}, 8'd0);
    if (hold_low) begin
      repeat (4) @(posedge clk);
      #2 strobe_n = 1'b1;
    end
    @(posedge clk); #5;
    chk(!rx_valid && !ctl_a_valid && !ctl_b_valid, "R4 single-cycle pulse",
        {5'd0, rx_valid, ctl_a_valid, ctl_b_valid}, 8'd0);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    #3;
    chk(tx_oe == 0 && rx_valid == 0 && ctl_a_valid == 0 && ctl_b_valid == 0, "R1 reset flags",
        {4'd0, tx_oe, rx_valid, ctl_a_valid, ctl_b_valid}, 8'd0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #5;
    chk(rx_word == 0, "R1 rx_word", rx_word, 8'd0);
    chk(ctl_a == 0, "R1 ctl_a", ctl_a, 8'd0);
    chk(ctl_b == 0, "R1 ctl_b", ctl_b, 8'd0);
    chk(tx_oe == 0, "R1 oe", {7'd0, tx_oe}, 8'd0);

    slot(2'b00, 2'b00, 8'hB4, 8'hC1, 8'h3A, 1'b0, 1'b0, "R2 R3 R4 R5 low");
    slot(2'b01, 2'b01, 8'h81, 8'h7E, 8'h96, 1'b0, 1'b0, "R5 mid");
    slot(2'b10, 2'b10, 8'hFF, 8'h55, 8'h5C, 1'b0, 1'b0, "R6 R8 high");
    chk(ctl_a == cur_a, "R8 ctl_a kept", ctl_a, cur_a);
    chk(rx_word == 8'h7E, "R8 rx_word kept", rx_word, 8'h7E);
    slot(2'b11, 2'b11, 8'h00, 8'hAA, 8'hE1, 1'b0, 1'b0, "R6 high 11");
    slot(2'b00, 2'b00, 8'h01, 8'h80, 8'h01, 1'b0, 1'b1, "R7 held low");
    repeat (3) @(posedge clk);
    #1 chk(exp_q.size() == 0, "R7 no extra slot", 8'(exp_q.size()), 8'd0);
    slot(2'b00, 2'b10, 8'h69, 8'h2D, 8'hC7, 1'b0, 1'b0, "R10 late high");
    slot(2'b10, 2'b00, 8'h69, 8'h11, 8'h4B, 1'b0, 1'b0, "R10 late low");
    slot(2'b00, 2'b00, 8'h5A, 8'hE3, 8'h0F, 1'b1, 1'b0, "R9 loop");
    slot(2'b01, 2'b01, 8'h5A, 8'h36, 8'hF0, 1'b1, 1'b0, "R9 loop again");
    slot(2'b00, 2'b00, 8'hC3, 8'h9D, 8'h72, 1'b0, 1'b0, "R4 after loop");
    repeat (4) @(posedge clk);
    #1 chk(exp_q.size() == 0, "R4 all bytes seen", 8'(exp_q.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule